// File: doc/BRIEF.md
# Segmented Lower-Triangle Covariance Engine

The block forms the product R = X·Xᵀ for a signed fixed-point data matrix X of N rows and M columns. The matrix is too wide to keep on chip, so it arrives as a series of column segments over a valid/ready stream. Each segment is held in one of two input banks. While the arithmetic works through one bank, the other bank takes in the next segment. Because R is symmetric, only entries with row index at least equal to column index are formed. For each such pair of rows the engine streams the segment's columns, a few lanes per cycle, through a row of multipliers and a registered adder tree. It then adds the slice into a per-pair partial-sum store that persists from segment to segment.

A job begins with a start pulse in the idle state, which latches the row count, the segment width (in lane-wide chunks) and the number of segments. When the last segment has been computed and the tree has emptied, a one-cycle done pulse is raised. The N(N+1)/2 results then leave on a second valid/ready stream in row-major lower-triangle order, and the last one is flagged.

Top module: `covEngine`

## Requirements
- R1: While reset is held and directly after it is released, `inReady`, `resValid` and `done` are 0.
- R2: Every result equals the exact signed sum over all M columns of x[i][k]·x[j][k], where inputs are `DATA_W`-bit two's complement and results are `ACC_W` = 2·`DATA_W` + log2(maximum column count) bits signed.
- R3: An input beat carries `LANES` elements of one row, with lane l at bits [l·`DATA_W` +: `DATA_W`] holding segment column c·`LANES`+l for chunk c. Within a segment the beats run rows 0..N-1 in order, and inside each row the chunks run 0..chunks-1.
- R4: `start` latches `cfgRows` (1..`MAX_ROWS`), `cfgChunks` (1..`MAX_CHUNKS`) and `cfgSegs` (1..`MAX_SEGS`) only in the idle state, so M = segs·chunks·`LANES`. A `start` pulse or a changed configuration during a job has no effect on its results.
- R5: Partial sums carry over between segments, so a result covers the columns of every segment of the job.
- R6: The next segment is accepted while the previous one is computed. `inReady` is held low while one segment waits loaded and the other is still in use, and no beat is lost.
- R7: `done` is a one-cycle pulse raised in the same cycle as the first `resValid`, after the last segment has left the tree.
- R8: Results leave in row-major lower-triangle order: the pair (i, j) with j ≤ i is result number i(i+1)/2 + j. `resLast` is 1 only on the final one.
- R9: While `resValid` is 1 and `resReady` is 0, `resValid` and `resData` hold their values.
- R10: `inReady` is 0 outside the loading phase of a job, both in idle and during result readout.
- R11: A new job's results do not depend on data of an earlier job.
- R12: Inputs at the most negative value over the largest configured column count produce the exact sum without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Job start pulse, taken in idle only |
| cfgRows | input | ROWC_W | Row count N |
| cfgChunks | input | CHKC_W | Segment width in lane-wide chunks |
| cfgSegs | input | SEGC_W | Number of column segments |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted at this edge when valid |
| inData | input | LANES*DATA_W | One chunk of one row |
| done | output | 1 | Compute-complete pulse |
| resValid | output | 1 | Result valid |
| resReady | input | 1 | Result consumer ready |
| resData | output | ACC_W | Signed result value |
| resLast | output | 1 | Marks the final result |

## Verification
An input beat is taken at the edge after which `inReady` and `inValid` were both high at the preceding falling edge. The checks drive and sample on falling edges, so the handshake never depends on event order at the rising edge. The done pulse and the first result appear together, one cycle after the adder tree holds no valid slice. A result is consumed at the rising edge after `resValid` and `resReady` were seen high together, and the bench compares `resData` at that falling edge. The time from the last input beat to `done` depends on N, so the bench waits for the pulse rather than counting to it. It then checks that `resValid` is already high in that cycle and that `done` does not appear in any later readout cycle.

// File: rtl/covPkg.sv
package covPkg;
  localparam int DATA_W     = 8;
  localparam int LANES      = 4;
  localparam int MAX_ROWS   = 8;
  localparam int MAX_CHUNKS = 4;
  localparam int MAX_SEGS   = 16;

  localparam int TREE_LVLS  = $clog2(LANES);
  localparam int MAX_COLS   = MAX_SEGS * MAX_CHUNKS * LANES;
  localparam int ACC_W      = 2 * DATA_W + $clog2(MAX_COLS);
  localparam int ROW_W      = $clog2(MAX_ROWS);
  localparam int ROWC_W     = $clog2(MAX_ROWS + 1);
  localparam int CHK_W      = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1;
  localparam int CHKC_W     = $clog2(MAX_CHUNKS + 1);
  localparam int SEGC_W     = $clog2(MAX_SEGS + 1);
  localparam int PAIRS      = MAX_ROWS * (MAX_ROWS + 1) / 2;
  localparam int PAIR_W     = $clog2(PAIRS);
  localparam int BANK_DEPTH = MAX_ROWS * MAX_CHUNKS;
  localparam int BANK_AW    = $clog2(BANK_DEPTH);

  typedef struct packed {
    logic                wrEn;
    logic                wrBank;
    logic [BANK_AW-1:0]  wrAddr;
    logic                issue;
    logic                issBank;
    logic [BANK_AW-1:0]  addrA;
    logic [BANK_AW-1:0]  addrB;
    logic                firstChunk;
    logic                lastChunk;
    logic                firstSeg;
    logic [PAIR_W-1:0]   pairIdx;
    logic [PAIR_W-1:0]   rdIdx;
  } strobe_t;

  typedef struct packed {
    logic                firstChunk;
    logic                lastChunk;
    logic                firstSeg;
    logic [PAIR_W-1:0]   pairIdx;
  } tag_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_OUT} state_t;
endpackage

// File: rtl/covCtl.sv
module covCtl
  import covPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ROWC_W-1:0] cfgRows,
  input  logic [CHKC_W-1:0] cfgChunks,
  input  logic [SEGC_W-1:0] cfgSegs,
  input  logic              inValid,
  output logic              inReady,
  input  logic              resReady,
  input  logic              pipeBusy,
  output logic              done,
  output logic              resValid,
  output logic              resLast,
  output strobe_t           stb
);
  state_t             state;
  logic [ROWC_W-1:0]  nRows;
  logic [CHKC_W-1:0]  nChunks;
  logic [SEGC_W-1:0]  nSegs, segsLoaded, compSeg;
  logic [ROW_W-1:0]   fRow, cRow, cCol;
  logic [CHK_W-1:0]   fChunk, cChunk;
  logic               fillBank, fillFull, compBusy;
  logic [PAIR_W-1:0]  pairCnt, rdIdx;
  logic               doneR;

  logic accept, swap, lastFill, lastChunkC, lastCol, lastRow, lastRead;
  int   totalPairs;

  always_comb begin
    totalPairs = int'(nRows) * (int'(nRows) + 1) / 2;
    inReady    = (state == ST_RUN) && !fillFull && (segsLoaded < nSegs);
    accept     = inValid && inReady;
    lastFill   = (int'(fRow) == int'(nRows) - 1) && (int'(fChunk) == int'(nChunks) - 1);
    swap       = (state == ST_RUN) && fillFull && !compBusy;
    lastChunkC = int'(cChunk) == int'(nChunks) - 1;
    lastCol    = cCol == cRow;
    lastRow    = int'(cRow) == int'(nRows) - 1;
    lastRead   = int'(rdIdx) == totalPairs - 1;
    resValid   = state == ST_OUT;
    resLast    = resValid && lastRead;
    done       = doneR;

    stb            = '0;
    stb.wrEn       = accept;
    stb.wrBank     = fillBank;
    stb.wrAddr     = BANK_AW'(int'(fRow) * MAX_CHUNKS + int'(fChunk));
    stb.issue      = compBusy && (state == ST_RUN);
    stb.issBank    = ~fillBank;
    stb.addrA      = BANK_AW'(int'(cRow) * MAX_CHUNKS + int'(cChunk));
    stb.addrB      = BANK_AW'(int'(cCol) * MAX_CHUNKS + int'(cChunk));
    stb.firstChunk = cChunk == '0;
    stb.lastChunk  = lastChunkC;
    stb.firstSeg   = int'(compSeg) == 1;
    stb.pairIdx    = pairCnt;
    stb.rdIdx      = rdIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      nRows      <= '0;
      nChunks    <= '0;
      nSegs      <= '0;
      segsLoaded <= '0;
      compSeg    <= '0;
      fRow       <= '0;
      fChunk     <= '0;
      cRow       <= '0;
      cCol       <= '0;
      cChunk     <= '0;
      fillBank   <= 1'b0;
      fillFull   <= 1'b0;
      compBusy   <= 1'b0;
      pairCnt    <= '0;
      rdIdx      <= '0;
      doneR      <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          nRows      <= cfgRows;
          nChunks    <= cfgChunks;
          nSegs      <= cfgSegs;
          segsLoaded <= '0;
          compSeg    <= '0;
          fRow       <= '0;
          fChunk     <= '0;
          fillFull   <= 1'b0;
          compBusy   <= 1'b0;
          state      <= ST_RUN;
        end
        ST_RUN: begin
          if (accept) begin
            if (lastFill) begin
              fRow       <= '0;
              fChunk     <= '0;
              fillFull   <= 1'b1;
              segsLoaded <= segsLoaded + 1'b1;
            end else if (int'(fChunk) == int'(nChunks) - 1) begin
              fChunk <= '0;
              fRow   <= fRow + 1'b1;
            end else begin
              fChunk <= fChunk + 1'b1;
            end
          end
          if (swap) begin
            fillBank <= ~fillBank;
            fillFull <= 1'b0;
            compBusy <= 1'b1;
            compSeg  <= compSeg + 1'b1;
            cRow     <= '0;
            cCol     <= '0;
            cChunk   <= '0;
            pairCnt  <= '0;
          end else if (compBusy) begin
            if (!lastChunkC) begin
              cChunk <= cChunk + 1'b1;
            end else begin
              cChunk  <= '0;
              pairCnt <= pairCnt + 1'b1;
              if (!lastCol) begin
                cCol <= cCol + 1'b1;
              end else if (!lastRow) begin
                cCol <= '0;
                cRow <= cRow + 1'b1;
              end else begin
                compBusy <= 1'b0;
                if (compSeg == nSegs) state <= ST_DRAIN;
              end
            end
          end
        end
        ST_DRAIN: if (!pipeBusy) begin
          state <= ST_OUT;
          doneR <= 1'b1;
          rdIdx <= '0;
        end
        default: if (resReady) begin
          rdIdx <= rdIdx + 1'b1;
          if (lastRead) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R2: only pairs on or below the diagonal are ever issued
  a_r2_lower_tri: assert property (@(posedge clk) disable iff (!rstN)
    stb.issue |-> (cCol <= cRow));
  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: first result coincides with done
  a_r7_done_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> done);
  // R10: input only accepted while a job loads
  a_r10_ready_run: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (state == ST_RUN));
  // R9: readout index frozen under stall
  a_r9_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(rdIdx)));
endmodule

// File: rtl/covDp.sv
module covDp
  import covPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [LANES*DATA_W-1:0]   inData,
  input  strobe_t                   stb,
  output logic                      pipeBusy,
  output logic signed [ACC_W-1:0]   resData
);
  logic [LANES*DATA_W-1:0] bankMem [2][BANK_DEPTH];
  logic [LANES*DATA_W-1:0] opA, opB;
  logic                    vld  [TREE_LVLS+1];
  tag_t                    tagP [TREE_LVLS+1];
  logic signed [ACC_W-1:0] accStore [PAIRS];
  logic signed [ACC_W-1:0] runSum, treeOut;

  function automatic logic signed [ACC_W-1:0] mulExt(input logic [DATA_W-1:0] a,
                                                     input logic [DATA_W-1:0] b);
    logic signed [2*DATA_W-1:0] p;
    p = $signed(a) * $signed(b);
    return {{(ACC_W-2*DATA_W){p[2*DATA_W-1]}}, p};
  endfunction

  always_ff @(posedge clk) begin
    if (stb.wrEn) bankMem[stb.wrBank][stb.wrAddr] <= inData;
  end

  always_comb begin
    opA = bankMem[stb.issBank][stb.addrA];
    opB = bankMem[stb.issBank][stb.addrB];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k <= TREE_LVLS; k++) begin
        vld[k]  <= 1'b0;
        tagP[k] <= '0;
      end
    end else begin
      vld[0]  <= stb.issue;
      tagP[0] <= '{firstChunk: stb.firstChunk, lastChunk: stb.lastChunk,
                   firstSeg: stb.firstSeg, pairIdx: stb.pairIdx};
      for (int k = 1; k <= TREE_LVLS; k++) begin
        vld[k]  <= vld[k-1];
        tagP[k] <= tagP[k-1];
      end
    end
  end

  for (genvar lvl = 0; lvl <= TREE_LVLS; lvl++) begin : g_lvl
    localparam int NODES = LANES >> lvl;
    logic signed [ACC_W-1:0] node [NODES];
    if (lvl == 0) begin : g_mul
      always_ff @(posedge clk) begin
        for (int l = 0; l < NODES; l++)
          node[l] <= mulExt(opA[l*DATA_W +: DATA_W], opB[l*DATA_W +: DATA_W]);
      end
    end else begin : g_add
      always_ff @(posedge clk) begin
        for (int n = 0; n < NODES; n++)
          node[n] <= g_lvl[lvl-1].node[2*n] + g_lvl[lvl-1].node[2*n+1];
      end
    end
  end

  assign treeOut = g_lvl[TREE_LVLS].node[0];

  always_ff @(posedge clk) begin
    if (!rstN) runSum <= '0;
    else if (vld[TREE_LVLS] && !tagP[TREE_LVLS].lastChunk)
      runSum <= (tagP[TREE_LVLS].firstChunk ? '0 : runSum) + treeOut;
  end

  always_ff @(posedge clk) begin
    if (vld[TREE_LVLS] && tagP[TREE_LVLS].lastChunk)
      accStore[tagP[TREE_LVLS].pairIdx] <=
        (tagP[TREE_LVLS].firstSeg ? '0 : accStore[tagP[TREE_LVLS].pairIdx]) +
        (tagP[TREE_LVLS].firstChunk ? '0 : runSum) + treeOut;
  end

  always_comb begin
    pipeBusy = 1'b0;
    for (int k = 0; k <= TREE_LVLS; k++) pipeBusy = pipeBusy | vld[k];
    resData = accStore[stb.rdIdx];
  end

  // R6: the filling bank is never the bank feeding the multipliers
  a_r6_bank_split: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && stb.issue) |-> (stb.wrBank != stb.issBank));
  // R5: a slice chain always opens with a first chunk
  a_r5_chain_open: assert property (@(posedge clk) disable iff (!rstN)
    (vld[0] && !tagP[0].firstChunk) |-> $past(stb.issue, 2));
endmodule

// File: rtl/covEngine.sv
module covEngine
  import covPkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [ROWC_W-1:0]         cfgRows,
  input  logic [CHKC_W-1:0]         cfgChunks,
  input  logic [SEGC_W-1:0]         cfgSegs,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [LANES*DATA_W-1:0]   inData,
  output logic                      done,
  output logic                      resValid,
  input  logic                      resReady,
  output logic signed [ACC_W-1:0]   resData,
  output logic                      resLast
);
  strobe_t stb;
  logic    pipeBusy;

  covCtl u_ctl (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgRows(cfgRows), .cfgChunks(cfgChunks), .cfgSegs(cfgSegs),
    .inValid(inValid), .inReady(inReady), .resReady(resReady),
    .pipeBusy(pipeBusy), .done(done), .resValid(resValid),
    .resLast(resLast), .stb(stb)
  );

  covDp u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .stb(stb),
    .pipeBusy(pipeBusy), .resData(resData)
  );

  // R9: stalled result stays put
  a_r9_res_hold: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(resData)));
endmodule

// File: tb/sim_covEngine.sv
module sim_covEngine;
  import covPkg::*;

  logic clk = 1'b0;
  logic rstN, start, inValid, resReady;
  logic [ROWC_W-1:0] cfgRows;
  logic [CHKC_W-1:0] cfgChunks;
  logic [SEGC_W-1:0] cfgSegs;
  logic [LANES*DATA_W-1:0] inData;
  logic inReady, done, resValid, resLast;
  logic signed [ACC_W-1:0] resData;

  int nChecks = 0;
  int nFails  = 0;
  logic signed [DATA_W-1:0] mat [MAX_ROWS][MAX_COLS];
  longint expv [PAIRS];

  always #2 clk = ~clk;

  covEngine u0 (
    .clk(clk), .rstN(rstN), .start(start), .cfgRows(cfgRows),
    .cfgChunks(cfgChunks), .cfgSegs(cfgSegs), .inValid(inValid),
    .inReady(inReady), .inData(inData), .done(done), .resValid(resValid),
    .resReady(resReady), .resData(resData), .resLast(resLast)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  // One job: build data, compute reference, load, read back and compare.
  task automatic runJob(input int n, input int ch, input int sg, input int mode,
                        input bit stallOut, input bit glitch, input bit expectStall,
                        input string req);
    int cols = sg * ch * LANES;
    int total = n * (n + 1) / 2;
    bit sawStall = 0;
    for (int r = 0; r < n; r++)
      for (int c = 0; c < cols; c++)
        mat[r][c] = (mode == 1) ? -(2 ** (DATA_W - 1)) : DATA_W'($urandom);
    for (int i = 0; i < n; i++)
      for (int j = 0; j <= i; j++) begin
        longint s = 0;
        for (int c = 0; c < cols; c++) s += longint'(mat[i][c]) * longint'(mat[j][c]);
        expv[i * (i + 1) / 2 + j] = s;
      end

    @(negedge clk);
    cfgRows = ROWC_W'(n); cfgChunks = CHKC_W'(ch); cfgSegs = SEGC_W'(sg); start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    fork
      begin : feeder
        for (int s = 0; s < sg; s++)
          for (int r = 0; r < n; r++)
            for (int c = 0; c < ch; c++) begin
              @(negedge clk);
              inValid = 1'b1;
              for (int l = 0; l < LANES; l++)
                inData[l*DATA_W +: DATA_W] = mat[r][s*ch*LANES + c*LANES + l];
              while (!inReady) begin
                sawStall = 1;
                @(negedge clk);
              end
              @(posedge clk);
              if (glitch && s == 0 && r == 0 && c == 0) begin
                @(negedge clk);
                inValid = 1'b0;
                start = 1'b1; cfgRows = 1; cfgSegs = 1; cfgChunks = 1;
                @(negedge clk);
                start = 1'b0;
              end
            end
        @(negedge clk);
        inValid = 1'b0;
      end
      begin : reader
        int k = 0;
        int extraDone = 0;
        bit first = 1;
        bit held = 0;
        longint heldVal = 0;
        @(negedge clk);
        while (!done) @(negedge clk);
        check(resValid == 1'b1, "R7", "resValid with done", resValid, 1);
        check(inReady == 1'b0, "R10", "inReady during readout", inReady, 0);
        while (k < total) begin
          if (!first) @(negedge clk);
          if (!first && done) extraDone++;
          first = 0;
          if (held)
            check(longint'(resData) == heldVal && resValid, "R9", "held result",
                  longint'(resData), heldVal);
          resReady = stallOut ? ($urandom_range(0, 2) != 0) : 1'b1;
          if (resValid && resReady) begin
            check(longint'(resData) == expv[k], req, $sformatf("result %0d", k),
                  longint'(resData), expv[k]);
            check(resLast == (k == total - 1), "R8", $sformatf("last flag %0d", k),
                  resLast, (k == total - 1));
            k++;
            held = 0;
          end else begin
            held = resValid;
            heldVal = longint'(resData);
          end
        end
        @(negedge clk);
        resReady = 1'b0;
        check(extraDone == 0, "R7", "done pulses after first", extraDone, 0);
        check(resValid == 1'b0, "R8", "stream closed after last", resValid, 0);
      end
    join
    if (expectStall) check(sawStall, "R6", "back-pressure seen", sawStall, 1);
  endtask

  task automatic t_reset();
    // R1, R10
    check(inReady == 0 && resValid == 0 && done == 0, "R1", "outputs in reset",
          {inReady, resValid, done}, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(inReady == 0 && resValid == 0 && done == 0, "R1", "outputs after reset",
          {inReady, resValid, done}, 0);
    inValid = 1'b1;
    repeat (3) @(negedge clk);
    check(inReady == 0, "R10", "inReady in idle", inReady, 0);
    inValid = 1'b0;
  endtask

  task automatic t_basic();       runJob(4, 1, 1, 0, 0, 0, 0, "R2");  endtask
  task automatic t_multiSeg();    runJob(5, 2, 3, 0, 0, 0, 1, "R5");  endtask
  task automatic t_lanes();       runJob(3, 3, 2, 0, 0, 0, 0, "R3");  endtask
  task automatic t_outStall();    runJob(6, 2, 2, 0, 1, 0, 0, "R9");  endtask
  task automatic t_startIgnored();runJob(4, 2, 2, 0, 0, 1, 0, "R4");  endtask
  task automatic t_extreme();     runJob(2, MAX_CHUNKS, MAX_SEGS, 1, 0, 0, 0, "R12"); endtask
  task automatic t_fullRows();    runJob(MAX_ROWS, MAX_CHUNKS, 2, 0, 1, 0, 1, "R8"); endtask
  task automatic t_single();      runJob(1, 1, 4, 0, 0, 0, 0, "R5");  endtask
  task automatic t_rerun();       runJob(4, 1, 1, 0, 0, 0, 0, "R11"); endtask

  initial begin
    rstN = 1'b0; start = 1'b0; inValid = 1'b0; resReady = 1'b0;
    cfgRows = '0; cfgChunks = '0; cfgSegs = '0; inData = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_multiSeg();
    t_lanes();
    t_outStall();
    t_startIgnored();
    t_extreme();
    t_fullRows();
    t_single();
    t_rerun();
    @(negedge clk);
    check(inReady == 0, "R10", "inReady idle after jobs", inReady, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule